// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from 24 hardware sources, arranged as three banks of eight, and presents the most urgent one to a CPU as a vector byte. A rising edge on a source line latches a posted bit for that source. A posted bit becomes pending only while its mask bit is set. A fixed-priority encoder picks the pending source with the lowest index and produces its vector. The CPU sees an interrupt request only while its global interrupt enable is high.

Software reaches the block through a small register port with seven addresses. The port covers three posted/clear banks, three mask banks and one vector register. A global software-post enable sits in the top bit of the last mask bank. It selects how writes to the posted/clear banks are read: as clears or as software posts. An acknowledge strobe from the CPU retires the source currently selected. Any write to the vector address empties the whole posted set.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every posted bit, every mask bit and the software-post enable are 0. Reads of all seven addresses return 00h and `irq` is 0.
- R2: A 0-to-1 transition on `hw_req[n]` sets posted bit n. A line that stays high does not set it again once it is cleared. Reading address b (0..2) returns the posted bits of sources 8b..8b+7, with source 8b+i in bit i.
- R3: Address 3+b (b = 0..2) holds the mask bits of sources 8b..8b+7, with bit i for source 8b+i. A posted source whose mask bit is 0 is never selected, and each mask bit acts alone. Bit 7 of address 5 is the software-post enable, not a mask, so source 23 can post but never becomes pending.
- R4: While the software-post enable is 0, writing 0 to a bit of address 0..2 clears that posted bit. Writing 1 leaves the bit unchanged.
- R5: While the software-post enable is 1, writing 1 to a bit of address 0..2 sets that posted bit. Writing 0 leaves the bit unchanged.
- R6: Reading address 6 returns 4*(n+1), where n is the lowest-indexed pending source. It returns 00h when no source is pending.
- R7: A one-cycle `vec_ack` clears the posted bit of the source that was selected in that cycle. No other bit changes.
- R8: A write to address 6, whatever its data, clears every posted bit.
- R9: `irq` is 1 exactly when `gie` is 1 and at least one source is pending.
- R10: In the same cycle, a hardware rising edge on a source takes precedence over a software clear of that source's posted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 24 | Hardware request lines, one per source |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_ack | input | 1 | Vector acknowledge from the CPU |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The embedded assertions check five behaviours on every cycle:
- a selected source is always both posted and unmasked;
- `irq` never rises without gating and a posted source;
- a flush empties the posted set;
- an acknowledge retires the selected source;
- a bank write under either enable setting only ever moves bits in the permitted direction.

Only the bench's scenarios can show other behaviours. These are the exact vector value for each source, the ascending retirement order under repeated acknowledges, the independence of single mask bits, the held-level no-repost rule and the same-cycle precedence of a hardware edge over a clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int ADDR_W    = 3;
    localparam int SWEN_BIT  = NUM_SRC - 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_POST0 = 3'd0,
        RA_POST1 = 3'd1,
        RA_POST2 = 3'd2,
        RA_MASK0 = 3'd3,
        RA_MASK1 = 3'd4,
        RA_MASK2 = 3'd5,
        RA_VECT  = 3'd6,
        RA_NONE  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [BANK_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [BANK_W-1:0] v;
        v = BANK_W'(idx) + BANK_W'(1);
        return v << 2;
    endfunction
endpackage

// File: rtl/intc_post_bank.sv
module intc_post_bank
    import intc_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_req,
    input  logic         bank_wr,
    input  logic [W-1:0] wdata,
    input  logic         swen,
    input  logic [W-1:0] ack_clr,
    input  logic         flush,
    output logic [W-1:0] posted
);
    logic [W-1:0] hw_q;
    logic [W-1:0] rise;
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        rise  = hw_req & ~hw_q;
        set_v = rise | ((bank_wr && swen) ? wdata : '0);
        clr_v = ack_clr | (flush ? '1 : '0) | ((bank_wr && !swen) ? ~wdata : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q   <= '0;
            posted <= '0;
        end else begin
            hw_q   <= hw_req;
            posted <= set_v | (posted & ~clr_v);
        end
    end

    AST_CLR_ONES_NOOP: assert property (@(posedge clk) disable iff (rst)
        (bank_wr && !swen && hw_req == '0) |=> ((posted & ~$past(posted)) == '0)); // R4

    AST_SW_ZEROS_NOOP: assert property (@(posedge clk) disable iff (rst)
        (bank_wr && swen && ack_clr == '0 && !flush) |=> (($past(posted) & ~posted) == '0)); // R5
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc
    import intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] pend,
    output pick_t        pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [BANK_W-1:0]  reg_wdata,
    output logic [BANK_W-1:0]  reg_rdata,
    input  logic               vec_ack,
    input  logic               gie,
    output logic               irq
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_eff;
    logic [NUM_SRC-1:0] posted_all;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_vec;
    logic               swen;
    logic               flush;
    pick_t              pick;
    reg_addr_e          ra;

    assign ra       = reg_addr_e'(reg_addr);
    assign swen     = mask_q[SWEN_BIT];
    assign mask_eff = mask_q & ~(NUM_SRC'(1) << SWEN_BIT);
    assign pend     = posted_all & mask_eff;
    assign flush    = reg_we && (ra == RA_VECT);
    assign ack_vec  = (vec_ack && pick.valid) ? (NUM_SRC'(1) << pick.idx) : '0;
    assign irq      = gie && pick.valid;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        intc_post_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .hw_req  (hw_req[b*BANK_W +: BANK_W]),
            .bank_wr (reg_we && (reg_addr == ADDR_W'(b))),
            .wdata   (reg_wdata),
            .swen    (swen),
            .ack_clr (ack_vec[b*BANK_W +: BANK_W]),
            .flush   (flush),
            .posted  (posted_all[b*BANK_W +: BANK_W])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[b*BANK_W +: BANK_W] <= '0;
            end else if (reg_we && reg_addr == ADDR_W'(NUM_BANKS + b)) begin
                mask_q[b*BANK_W +: BANK_W] <= reg_wdata;
            end
        end
    end

    intc_prio_enc #(.N(NUM_SRC)) u_enc (
        .pend (pend),
        .pick (pick)
    );

    always_comb begin
        unique case (ra)
            RA_POST0: reg_rdata = posted_all[0*BANK_W +: BANK_W];
            RA_POST1: reg_rdata = posted_all[1*BANK_W +: BANK_W];
            RA_POST2: reg_rdata = posted_all[2*BANK_W +: BANK_W];
            RA_MASK0: reg_rdata = mask_q[0*BANK_W +: BANK_W];
            RA_MASK1: reg_rdata = mask_q[1*BANK_W +: BANK_W];
            RA_MASK2: reg_rdata = mask_q[2*BANK_W +: BANK_W];
            RA_VECT:  reg_rdata = pick.valid ? vec_of(pick.idx) : '0;
            default:  reg_rdata = '0;
        endcase
    end

    AST_PICK_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (mask_q[pick.idx] && posted_all[pick.idx] && pick.idx != IDX_W'(SWEN_BIT))); // R3

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && pick.valid && !hw_req[pick.idx] && !reg_we) |=> !posted_all[$past(pick.idx)]); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (flush && hw_req == '0) |=> (posted_all == '0)); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gie && (posted_all & mask_q) != '0)); // R9
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] hw_req = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        vec_ack = 1'b0;
    logic        gie = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prio_vec_intc u_dut (
        .clk(clk), .rst(rst), .hw_req(hw_req), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_ack(vec_ack), .gie(gie), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_addr  = 3'(a);
        reg_wdata = 8'(d);
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        reg_addr = 3'(a);
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic pulse(input int n);
        hw_req[n] = 1'b1;
        tick();
        hw_req[n] = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk("R1", a, 0);
        chk("R1 irq", int'(irq), 0);

        // R2 R3 R6 R9 R4: per-source sweep
        gie = 1'b1;
        for (int n = 0; n < 24; n++) begin
            pulse(n);
            rd_chk("R2", n / 8, 1 << (n % 8));
            rd_chk("R3 masked", 6, 0);
            chk("R9 masked", int'(irq), 0);
            if (n < 23) wr(3 + n / 8, 1 << (n % 8));
            rd_chk("R6", 6, (n < 23) ? 4 * (n + 1) : 0);
            chk("R9", int'(irq), (n < 23) ? 1 : 0);
            gie = 1'b0;
            #1;
            chk("R9 gie", int'(irq), 0);
            gie = 1'b1;
            wr(n / 8, ~(1 << (n % 8)) & 8'hFF);
            rd_chk("R4 clear", n / 8, 0);
            chk("R9 idle", int'(irq), 0);
            wr(3 + n / 8, 0);
        end

        // R2 held level does not repost
        hw_req[3] = 1'b1;
        tick();
        rd_chk("R2 level", 0, 8'h08);
        wr(0, 8'hF7);
        tick();
        rd_chk("R2 norepost", 0, 0);
        hw_req[3] = 1'b0;
        tick();

        // R4 ones no effect, zero clears one bit
        pulse(2);
        pulse(5);
        wr(0, 8'hFF);
        rd_chk("R4 ones", 0, 8'h24);
        wr(0, 8'hFB);
        rd_chk("R4 zero", 0, 8'h20);

        // R5 software posting
        wr(5, 8'h80);
        rd_chk("R5 swen", 5, 8'h80);
        wr(1, 8'h81);
        rd_chk("R5 post", 1, 8'h81);
        wr(1, 8'h00);
        rd_chk("R5 zeros", 1, 8'h81);
        rd_chk("R5 other", 0, 8'h20);

        // R8 flush
        wr(6, 8'h5A);
        for (int a = 0; a < 3; a++) rd_chk("R8", a, 0);

        // R3 independence, R6 priority, R7 ack order
        wr(0, 8'hFF);
        wr(1, 8'hFF);
        wr(2, 8'hFF);
        wr(4, 8'h10);
        rd_chk("R3 single", 6, 52);
        wr(3, 8'hFF);
        wr(4, 8'hFF);
        wr(5, 8'hFF);
        for (int k = 0; k < 23; k++) begin
            rd_chk("R6 order", 6, 4 * (k + 1));
            vec_ack = 1'b1;
            tick();
            vec_ack = 1'b0;
            rd_chk("R7", k / 8, (8'hFF << ((k % 8) + 1)) & 8'hFF);
        end
        rd_chk("R6 empty", 6, 0);
        rd_chk("R3 src23", 2, 8'h80);
        chk("R9 empty", int'(irq), 0);

        // R10 hardware edge beats same-cycle clear
        wr(6, 0);
        wr(5, 8'h00);
        pulse(0);
        hw_req[1] = 1'b1;
        wr(0, 8'h00);
        rd_chk("R10", 0, 8'h02);
        hw_req[1] = 1'b0;
        tick();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule